// File: doc/BRIEF.md
# Snapshot-read 64-bit tick counter

This block keeps a free-running up-counter that advances by one on every clock in which the oscillator tick input is high. Software on a 32-bit register port cannot read a 64-bit value in one access. To get a coherent reading it asks for a snapshot first.

Software writes a control word with the request bit set. The block shows the request as pending for a fixed number of cycles, which stands for clock-domain synchronisation. It then copies the live count into a holding register and drops the request bit. Software polls the control word until the request bit reads 0. It then fetches the two halves of the held value from their own addresses. Both halves come from the same instant, so they always form one consistent value. The counter itself keeps running the whole time.

Top module: `latched_tick_counter`

## Requirements
- R1: After reset the count, the held snapshot and the request bit are all zero. Reads of the control, low and high registers return 0.
- R2: The count rises by exactly one at each rising clock edge where `tick` is 1. It holds its value when `tick` is 0.
- R3: A write to the control offset 0xA0 with bit 1 (value 0x02) set, while no request is pending, starts a latch. From the next cycle, bit 1 of the control register reads 1 for exactly `LATCH_DELAY` cycles (default 2). It then reads 0.
- R4: When a latch completes, the snapshot takes the count value present in the last cycle in which the request bit still read 1.
- R5: The low register at 0xA4 returns snapshot bits [31:0] and the high register at 0xA8 returns bits [63:32]. Both stay unchanged between latches, however far the live count moves.
- R6: A write of the request bit while a latch is pending is ignored. The latch completes at its original time with its original value.
- R7: A control write with bit 1 clear has no effect. No latch starts and the snapshot is unchanged.
- R8: The count wraps to zero after its all-ones value, modulo 2^`CNT_W`.
- R9: Successive snapshots never decrease while the counter has not wrapped.
- R10: Control bits other than bit 1 read 0, and unmapped offsets read 0. Writes to the low and high offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oscillator tick; count enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |

## Verification
The bench targets the following corner cases.

- **Snapshot timing.** The bench predicts the exact cycle at which the snapshot is taken. A design that captured one cycle early or late would return a value off by the ticks in that cycle, and the sparse and alternating tick patterns expose this.
- **Repeated request while pending.** A design that honoured this write would stretch the pending window, and the bench would see the request bit still 1 after `LATCH_DELAY` cycles.
- **Write with bit 1 clear.** A design that started a latch on this write would show the request bit set.
- **Stale halves.** Reads taken long after a latch, with the counter still running, catch a design that returns the live count instead of the held one.
- **Wrap-around.** A narrow instance left running past its all-ones value shows whether the count wraps modulo 2^`CNT_W`.

// File: rtl/latched_tick_counter.sv
module latched_tick_counter #(
  parameter int CNT_W       = 64,
  parameter int LATCH_DELAY = 2,
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'hA0,
  parameter logic [ADDR_W-1:0] LO_OFS   = 8'hA4,
  parameter logic [ADDR_W-1:0] HI_OFS   = 8'hA8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data
);
  localparam int HALF    = CNT_W / 2;
  localparam int WW      = (LATCH_DELAY > 1) ? $clog2(LATCH_DELAY) : 1;
  localparam int REQ_BIT = 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] snap;
  logic             pend;
  logic [WW-1:0]    wait_cnt;
  logic             take;

  assign take = wr_en && (addr == CTRL_OFS) && wr_data[REQ_BIT] && !pend;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      wait_cnt <= '0;
      snap     <= '0;
    end else if (take) begin
      pend     <= 1'b1;
      wait_cnt <= WW'(LATCH_DELAY - 1);
    end else if (pend) begin
      if (wait_cnt == '0) begin
        pend <= 1'b0;
        snap <= cnt;
      end else begin
        wait_cnt <= wait_cnt - 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == CTRL_OFS)    rd_data[REQ_BIT] = pend;
    else if (addr == LO_OFS) rd_data = 32'(snap[HALF-1:0]);
    else if (addr == HI_OFS) rd_data = 32'(snap[CNT_W-1:HALF]);
  end
endmodule

module latched_tick_counter_chk #(
  parameter int CNT_W       = 64,
  parameter int LATCH_DELAY = 2,
  parameter int ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'hA0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wr_data,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  snap,
  input logic              pend,
  input logic [((LATCH_DELAY > 1) ? $clog2(LATCH_DELAY) : 1)-1:0] wait_cnt
);
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + 1'b1);

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  assert_pending_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && wait_cnt != '0) |=> pend && wait_cnt == $past(wait_cnt) - 1'b1);

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && wait_cnt == '0) |=> !pend && snap == $past(cnt));

  assert_snap_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && wait_cnt == '0) |=> $stable(snap));

  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !(wr_en && addr == CTRL_OFS && wr_data[1])) |=> !pend);
endmodule

bind latched_tick_counter latched_tick_counter_chk #(
  .CNT_W(CNT_W), .LATCH_DELAY(LATCH_DELAY), .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .cnt(cnt), .snap(snap), .pend(pend), .wait_cnt(wait_cnt)
);

// File: tb/latched_tick_counter_tb.sv
module latched_tick_counter_tb;
  localparam int D = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, rd_w;

  int checks = 0, errors = 0;
  int tick_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [63:0] ref_cnt = '0;
  logic [7:0]  ref_w = '0;
  logic [63:0] exp_q[$];
  logic [7:0]  expw_q[$];
  logic [63:0] last_snap = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  latched_tick_counter #(.LATCH_DELAY(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data));

  latched_tick_counter #(.CNT_W(8), .LATCH_DELAY(D)) u_wrap (
    .clk(clk), .rst_n(rst_n), .tick(1'b1), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_w));

  always @(posedge clk) begin
    if (!rst_n) begin ref_cnt <= '0; ref_w <= '0; end
    else begin
      if (tick) ref_cnt <= ref_cnt + 1;
      ref_w <= ref_w + 1;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (tick_mode)
      0: tick <= 1'b0;
      1: tick <= 1'b1;
      2: tick <= ~tick;
      default: tick <= lfsr[0] & lfsr[3];
    endcase
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // driver: start a latch and push the expected snapshot into the queue
  task automatic start_latch(input bit dup);
    logic [31:0] d;
    @(negedge clk); addr = 8'hA0; wr_data = 32'h2; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!dup) wr_en = 1'b0;
    for (int i = 1; i <= D; i++) begin
      if (i > 1) begin @(negedge clk); wr_en = 1'b0; end
      if (i == D) begin exp_q.push_back(ref_cnt); expw_q.push_back(ref_w); end
      rd(8'hA0, d);
      check(dup ? "R6 pending during rewrite" : "R3 pending", 64'(d), 64'h2);
    end
    @(negedge clk); rd(8'hA0, d);
    check(dup ? "R6 completes on time" : "R3 cleared after delay", 64'(d), 64'h0);
  endtask

  // monitor: poll, read both halves, compare with the queue head
  task automatic collect();
    logic [31:0] c, lo, hi, lw, hw;
    logic [63:0] e;
    logic [7:0] ew;
    do begin @(negedge clk); rd(8'hA0, c); end while (c[1]);
    rd(8'hA4, lo); lw = rd_w;
    rd(8'hA8, hi); hw = rd_w;
    e = exp_q.pop_front(); ew = expw_q.pop_front();
    check("R4 R5 snapshot value", {hi, lo}, e);
    check("R8 wrap instance snapshot", {hw[3:0], lw[3:0]}, 64'(ew));
    check("R9 nondecreasing", 64'({hi, lo} >= last_snap), 64'h1);
    last_snap = {hi, lo};
  endtask

  task automatic snap_now(output logic [63:0] v);
    logic [31:0] lo, hi;
    @(negedge clk); rd(8'hA4, lo); rd(8'hA8, hi); v = {hi, lo};
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] a, b;
    repeat (3) @(negedge clk);
    rd(8'hA0, d); check("R1 ctrl after reset", 64'(d), 0);
    rd(8'hA4, d); check("R1 low after reset", 64'(d), 0);
    rd(8'hA8, d); check("R1 high after reset", 64'(d), 0);
    rst_n = 1'b1;
    rd(8'h00, d); check("R10 unmapped offset", 64'(d), 0);

    tick_mode = 1; repeat (10) @(negedge clk);
    start_latch(0); collect();
    tick_mode = 2; repeat (7) @(negedge clk);
    start_latch(0); collect();
    tick_mode = 3; repeat (13) @(negedge clk);
    start_latch(0); collect();

    // R2 hold: no ticks, two snapshots equal
    tick_mode = 0; repeat (3) @(negedge clk);
    start_latch(0); collect(); a = last_snap;
    repeat (5) @(negedge clk);
    start_latch(0); collect();
    check("R2 count holds without tick", last_snap, a);

    // R5 snapshot stays while the counter runs
    tick_mode = 1; repeat (20) @(negedge clk);
    snap_now(b); check("R5 held value unchanged", b, a);

    // R6 rewrite during pending
    start_latch(1); collect();

    // R7 control write with bit 1 clear, R10 other bits read 0
    snap_now(a);
    wr_reg(8'hA0, 32'hFFFF_FFFD);
    for (int i = 0; i < 3; i++) begin
      rd(8'hA0, d); check("R7 no latch started", 64'(d), 0);
      @(negedge clk);
    end
    snap_now(b); check("R7 snapshot unchanged", b, a);

    // R10 writes to data offsets change nothing
    wr_reg(8'hA4, 32'h1234_5678);
    wr_reg(8'hA8, 32'h9ABC_DEF0);
    snap_now(b); check("R10 data writes ignored", b, a);

    // R8 let the narrow instance wrap past 255
    tick_mode = 3; repeat (300) @(negedge clk);
    start_latch(0); collect();
    tick_mode = 2; repeat (9) @(negedge clk);
    start_latch(0); collect();

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule